// File: doc/BRIEF.md
# SDRAM Command Front End with Bank State

This block sits at the device side of a four-bank synchronous DRAM. On every rising clock edge it samples the chip-select, row-strobe, column-strobe, write-enable and data-mask pins. It also keeps the clock-enable level it saw on the edge before. From these it classifies the cycle as a command: deselect, no-op, activate, read, write, precharge, mode-register write, refresh, or a low-power entry or exit. It checks each command against the open or closed state of every bank and against the device's power mode.

Each decoded cycle shows up on the outputs one clock later. The outputs are the command code, the addressed bank, the auto-precharge flag, a data enable taken from the mask pin, and an illegal flag. The per-bank open state and the device mode are also visible at the ports. A surrounding controller model uses these outputs to drive its array, burst and refresh logic. The burst-in-progress condition comes in on a separate input.

Top module: `sdram_cmd_front`

## Requirements
- R1: Chip select high decodes as deselect (code 0) whatever the other pins are. Chip select low with row, column and write strobes all high decodes as no-op (code 1).
- R2: Row strobe low with column and write strobes high is activate (code 2) to the bank on `ba`. If that bank is closed, it opens the bank. If the bank is already open, `illegal` is raised.
- R3: Row strobe high with column strobe low is read (code 3, write enable high) or write (code 4, write enable low). `auto_pre` reports `a10`. It needs the target bank open, otherwise it is illegal. A legal access with `a10` high closes that bank.
- R4: Row and write strobes low with column strobe high is a precharge. With `a10` low it is a single-bank precharge (code 5) and closes only the bank on `ba`. With `a10` high it is precharge-all (code 6) and closes every bank.
- R5: Row, column and write strobes all low is a mode-register write (code 7). It is legal only while every bank is closed.
- R6: Row and column strobes low with write enable high is refresh (code 8) when clock enable was high on the previous edge and is high on this edge. When clock enable falls to low on this edge, the same pattern is self-refresh entry (code 9, mode 2). Both are legal only with all banks closed.
- R7: A deselect or no-op while clock enable falls from high to low enters power-down (code 10, mode 1). If `burst_busy` is high, it enters clock suspend instead (code 11, mode 3). Either entry is allowed with banks open or closed.
- R8: In any low-power mode (1, 2 or 3):
  - Each cycle with clock enable low is a hold (code 13) and changes nothing.
  - Clock enable rising with a deselect or no-op is an exit (code 14) back to mode 0.
  - Clock enable rising with any other pattern is illegal (code 15).
- R9: An illegal command leaves every bank's open state and the device mode unchanged.
- R10: `data_en` is high for a cycle only if `dqm` was low, the device was in mode 0 and at least one bank was open.
- R11: Outputs change one clock after the pins are sampled. During reset the outputs read code 0, no flags, all banks closed and mode 0, and the previous clock enable is taken as high.
- R12: The pattern with row and column strobes high and write enable low is illegal (code 15). In mode 0, a cycle whose previous clock enable was low is illegal (code 15) unless it is a deselect or no-op with clock enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask; low enables data |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge / precharge-all select |
| burst_busy | input | 1 | A burst is in progress |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Bank addressed by the command |
| auto_pre | output | 1 | Auto-precharge requested |
| data_en | output | 1 | Data path enabled this cycle |
| illegal | output | 1 | Command not allowed in current state |
| bank_open | output | 4 | Open state per bank |
| dev_mode | output | 2 | 0 run, 1 power-down, 2 self refresh, 3 suspend |

## Verification
The assertions check several properties on every cycle:
- an illegal command never changes bank or mode state;
- a legal activate always leaves its bank open;
- precharge-all and auto-precharge always leave the addressed banks closed;
- mode-register writes and refreshes are accepted only from the all-closed state;
- banks stay frozen in low-power modes;
- the data enable never rises without an open bank.

The choice between power-down and clock suspend, the exit conditions from each low-power mode, and decoding that depends on the previous clock-enable level can only be shown by the bench's directed sequences and its random runs against a reference model.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    typedef enum logic [3:0] {
        C_DESEL = 4'd0,
        C_NOP   = 4'd1,
        C_ACT   = 4'd2,
        C_READ  = 4'd3,
        C_WRITE = 4'd4,
        C_PRE   = 4'd5,
        C_PREA  = 4'd6,
        C_MRS   = 4'd7,
        C_REF   = 4'd8,
        C_SREF  = 4'd9,
        C_PDN   = 4'd10,
        C_SUSP  = 4'd11,
        C_RSVD  = 4'd12,
        C_HOLD  = 4'd13,
        C_EXIT  = 4'd14,
        C_BAD   = 4'd15
    } cmd_e;

    typedef enum logic [1:0] {
        M_RUN  = 2'd0,
        M_PDN  = 2'd1,
        M_SREF = 2'd2,
        M_SUSP = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        K_DESEL, K_NOP, K_ACT, K_READ, K_WRITE, K_PRE, K_MRS, K_REF, K_STOP
    } kind_e;

endpackage

// File: rtl/sdram_pin_classify.sv
module sdram_pin_classify
    import sdram_cmd_pkg::*;
(
    input  logic  cs_n,
    input  logic  ras_n,
    input  logic  cas_n,
    input  logic  we_n,
    output kind_e kind
);
    always_comb begin
        if (cs_n) begin
            kind = K_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  kind = K_NOP;
                3'b011:  kind = K_ACT;
                3'b101:  kind = K_READ;
                3'b100:  kind = K_WRITE;
                3'b010:  kind = K_PRE;
                3'b000:  kind = K_MRS;
                3'b001:  kind = K_REF;
                default: kind = K_STOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
    parameter int BANK_W = 2,
    localparam int NB = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              close_en,
    input  logic              close_all,
    input  logic [BANK_W-1:0] sel,
    output logic [NB-1:0]     open_q
);
    logic [NB-1:0] open_d;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        always_comb begin
            open_d[g] = open_q[g];
            if (close_all || (close_en && sel == BANK_W'(g))) begin
                open_d[g] = 1'b0;
            end
            if (open_en && sel == BANK_W'(g)) begin
                open_d[g] = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) open_q[g] <= 1'b0;
            else        open_q[g] <= open_d[g];
        end
    end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdram_cmd_pkg::*;
#(
    parameter int BANK_W = 2,
    localparam int NB = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              dqm,
    input  logic              cke,
    input  logic [BANK_W-1:0] ba,
    input  logic              a10,
    input  logic              burst_busy,
    output logic [3:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              auto_pre,
    output logic              data_en,
    output logic              illegal,
    output logic [NB-1:0]     bank_open,
    output logic [1:0]        dev_mode
);
    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic              ap;
        logic              den;
        logic              bad;
        mode_e             mode;
        logic              cke_prev;
    } st_t;

    st_t   st_d, st_q;
    kind_e kind;
    logic  open_en, close_en, close_all;
    logic  quiet, sel_open, any_open;

    sdram_pin_classify i_classify (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .kind  (kind)
    );

    sdram_bank_table #(.BANK_W(BANK_W)) i_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_en   (open_en),
        .close_en  (close_en),
        .close_all (close_all),
        .sel       (ba),
        .open_q    (bank_open)
    );

    assign quiet    = (kind == K_DESEL) || (kind == K_NOP);
    assign sel_open = bank_open[ba];
    assign any_open = |bank_open;

    always_comb begin
        st_d          = st_q;
        st_d.cke_prev = cke;
        st_d.bank     = ba;
        st_d.ap       = 1'b0;
        st_d.bad      = 1'b0;
        st_d.den      = !dqm && (st_q.mode == M_RUN) && any_open;
        open_en       = 1'b0;
        close_en      = 1'b0;
        close_all     = 1'b0;

        if (st_q.mode != M_RUN) begin
            if (!cke) begin
                st_d.cmd = C_HOLD;
            end else if (quiet) begin
                st_d.cmd  = C_EXIT;
                st_d.mode = M_RUN;
            end else begin
                st_d.cmd = C_BAD;
                st_d.bad = 1'b1;
            end
        end else if (!st_q.cke_prev) begin
            if (cke && quiet) begin
                st_d.cmd = (kind == K_DESEL) ? C_DESEL : C_NOP;
            end else begin
                st_d.cmd = C_BAD;
                st_d.bad = 1'b1;
            end
        end else begin
            case (kind)
                K_DESEL, K_NOP: begin
                    st_d.cmd = (kind == K_DESEL) ? C_DESEL : C_NOP;
                    if (!cke) begin
                        st_d.cmd  = burst_busy ? C_SUSP : C_PDN;
                        st_d.mode = burst_busy ? M_SUSP : M_PDN;
                    end
                end
                K_ACT: begin
                    st_d.cmd = C_ACT;
                    st_d.bad = sel_open;
                    open_en  = 1'b1;
                end
                K_READ, K_WRITE: begin
                    st_d.cmd = (kind == K_READ) ? C_READ : C_WRITE;
                    st_d.ap  = a10;
                    st_d.bad = !sel_open;
                    close_en = a10;
                end
                K_PRE: begin
                    st_d.cmd  = a10 ? C_PREA : C_PRE;
                    close_all = a10;
                    close_en  = !a10;
                end
                K_MRS: begin
                    st_d.cmd = C_MRS;
                    st_d.bad = any_open;
                end
                K_REF: begin
                    st_d.cmd = cke ? C_REF : C_SREF;
                    st_d.bad = any_open;
                    if (!cke) st_d.mode = M_SREF;
                end
                default: begin
                    st_d.cmd = C_BAD;
                    st_d.bad = 1'b1;
                end
            endcase
        end

        if (st_d.bad) begin
            open_en   = 1'b0;
            close_en  = 1'b0;
            close_all = 1'b0;
            st_d.mode = st_q.mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmd      <= C_DESEL;
            st_q.bank     <= '0;
            st_q.ap       <= 1'b0;
            st_q.den      <= 1'b0;
            st_q.bad      <= 1'b0;
            st_q.mode     <= M_RUN;
            st_q.cke_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_code = st_q.cmd;
    assign cmd_bank = st_q.bank;
    assign auto_pre = st_q.ap;
    assign data_en  = st_q.den;
    assign illegal  = st_q.bad;
    assign dev_mode = st_q.mode;

    AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == C_ACT && !illegal) |-> bank_open[cmd_bank]); // R2
    AST_AUTOPRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == C_READ || cmd_code == C_WRITE) && auto_pre && !illegal)
        |-> !bank_open[cmd_bank]); // R3
    AST_PREA_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == C_PREA) |-> (bank_open == '0)); // R4
    AST_MRS_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == C_MRS && !illegal) |-> ($past(bank_open) == '0)); // R5
    AST_REFRESH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == C_REF || cmd_code == C_SREF) && !illegal)
        |-> ($past(bank_open) == '0)); // R6
    AST_LOWPOWER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode != M_RUN) |-> $stable(bank_open)); // R8
    AST_ILLEGAL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(bank_open) && $stable(dev_mode))); // R9
    AST_DATA_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> ($past(bank_open) != '0)); // R10
endmodule

// File: tb/test_sdram_cmd_front.sv
module test_sdram_cmd_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       dqm = 1'b1, cke = 1'b1, a10 = 1'b0, burst_busy = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] cmd_code;
    logic [1:0] cmd_bank;
    logic       auto_pre, data_en, illegal;
    logic [3:0] bank_open;
    logic [1:0] dev_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0] m_open;
    logic [1:0] m_mode;
    logic       m_prev;

    always #2.5 clk = ~clk;

    sdram_cmd_front i_sdram_cmd_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .dqm(dqm), .cke(cke), .ba(ba), .a10(a10),
        .burst_busy(burst_busy), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .auto_pre(auto_pre), .data_en(data_en), .illegal(illegal),
        .bank_open(bank_open), .dev_mode(dev_mode)
    );

    function automatic string tag_of(input int c);
        case (c)
            0, 1:       return "R1";
            2:          return "R2";
            3, 4:       return "R3";
            5, 6:       return "R4";
            7:          return "R5";
            8, 9:       return "R6";
            10, 11:     return "R7";
            13, 14:     return "R8";
            default:    return "R12";
        endcase
    endfunction

    task automatic step(input logic c, input logic r, input logic k, input logic w,
                        input logic ck, input logic [1:0] b, input logic a,
                        input logic dm, input logic bz, input string tag);
        int e_cmd;
        logic e_bad, e_ap, e_den;
        logic [3:0] n_open;
        logic [1:0] n_mode;
        logic quiet;
        int kd;
        string t;
        cs_n = c; ras_n = r; cas_n = k; we_n = w; cke = ck;
        ba = b; a10 = a; dqm = dm; burst_busy = bz;
        // kind: 0 desel 1 nop 2 act 3 rd 4 wr 5 pre 6 mrs 7 ref 8 stop
        if (c) kd = 0;
        else case ({r, k, w})
            3'b111: kd = 1; 3'b011: kd = 2; 3'b101: kd = 3; 3'b100: kd = 4;
            3'b010: kd = 5; 3'b000: kd = 6; 3'b001: kd = 7; default: kd = 8;
        endcase
        quiet = (kd <= 1);
        e_bad = 1'b0; e_ap = 1'b0;
        e_den = !dm && (m_mode == 2'd0) && (m_open != 4'd0);
        n_open = m_open; n_mode = m_mode;
        if (m_mode != 2'd0) begin
            if (!ck) e_cmd = 13;
            else if (quiet) begin e_cmd = 14; n_mode = 2'd0; end
            else begin e_cmd = 15; e_bad = 1'b1; end
        end else if (!m_prev) begin
            if (ck && quiet) e_cmd = kd;
            else begin e_cmd = 15; e_bad = 1'b1; end
        end else begin
            case (kd)
                0, 1: begin
                    e_cmd = kd;
                    if (!ck) begin e_cmd = bz ? 11 : 10; n_mode = bz ? 2'd3 : 2'd1; end
                end
                2: begin e_cmd = 2; e_bad = m_open[b]; n_open[b] = 1'b1; end
                3, 4: begin
                    e_cmd = kd; e_ap = a; e_bad = !m_open[b];
                    if (a) n_open[b] = 1'b0;
                end
                5: begin
                    e_cmd = a ? 6 : 5;
                    if (a) n_open = 4'd0; else n_open[b] = 1'b0;
                end
                6: begin e_cmd = 7; e_bad = (m_open != 0); end
                7: begin
                    e_cmd = ck ? 8 : 9; e_bad = (m_open != 0);
                    if (!ck) n_mode = 2'd2;
                end
                default: begin e_cmd = 15; e_bad = 1'b1; end
            endcase
        end
        if (e_bad) begin n_open = m_open; n_mode = m_mode; end
        @(posedge clk);
        @(negedge clk);
        t = (tag == "") ? tag_of(e_cmd) : tag;
        checks++;
        if (cmd_code != 4'(e_cmd) || cmd_bank != b || auto_pre != e_ap ||
            data_en != e_den || illegal != e_bad || bank_open != n_open ||
            dev_mode != n_mode) begin
            failures++;
            $display("FAIL %s cmd=%0d/%0d bank=%0d/%0d ap=%0b/%0b den=%0b/%0b ill=%0b/%0b open=%b/%b mode=%0d/%0d",
                     t, cmd_code, e_cmd, cmd_bank, b, auto_pre, e_ap, data_en, e_den,
                     illegal, e_bad, bank_open, n_open, dev_mode, n_mode);
        end
        m_open = n_open; m_mode = n_mode; m_prev = ck;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_open = 4'd0; m_mode = 2'd0; m_prev = 1'b1;
        void'($urandom(32'h5D2A_0413));
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++; // R11 reset state
        if (cmd_code != 0 || illegal || data_en || auto_pre || bank_open != 0 || dev_mode != 0) begin
            failures++;
            $display("FAIL R11 reset cmd=%0d ill=%0b den=%0b open=%b mode=%0d expected 0", cmd_code,
                     illegal, data_en, bank_open, dev_mode);
        end
        rst_n = 1'b1;
        // directed corner cases: c r k w cke ba a10 dqm busy
        step(1,0,0,0, 1,2'd3,1,0,0, "R1");   // deselect regardless of strobes
        step(0,1,1,1, 1,2'd0,0,0,0, "R1");
        step(0,0,1,1, 1,2'd1,0,1,0, "R2");   // open bank 1
        step(0,0,1,1, 1,2'd1,0,1,0, "R9");   // reopen: illegal, frozen
        step(0,1,0,1, 1,2'd1,0,0,0, "R10");  // read, data enabled
        step(0,1,0,0, 1,2'd2,0,0,0, "R3");   // write to closed bank
        step(0,0,0,0, 1,2'd0,0,1,0, "R5");   // mrs with bank open
        step(0,1,0,0, 1,2'd1,1,1,0, "R3");   // write with auto-precharge
        step(0,0,1,1, 1,2'd0,0,1,0, "R2");
        step(0,0,1,1, 1,2'd3,0,1,0, "R2");
        step(0,0,1,0, 1,2'd0,0,1,0, "R4");   // single precharge bank 0
        step(0,0,0,1, 1,2'd0,0,1,0, "R6");   // refresh with bank 3 open
        step(0,0,1,0, 1,2'd2,1,1,0, "R4");   // precharge all
        step(0,0,0,0, 1,2'd0,0,1,0, "R5");
        step(0,0,0,1, 1,2'd0,0,1,0, "R6");
        step(0,0,1,1, 1,2'd2,0,1,0, "R2");
        step(0,1,1,1, 0,2'd0,0,0,1, "R7");   // suspend
        step(0,1,1,1, 0,2'd0,0,0,1, "R8");
        step(0,1,1,1, 1,2'd0,0,0,0, "R8");
        step(1,1,1,1, 0,2'd0,0,0,0, "R7");   // power-down
        step(0,0,1,1, 1,2'd0,0,0,0, "R8");   // non-quiet wake: illegal
        step(1,0,0,0, 1,2'd0,0,0,0, "R8");   // exit
        step(0,1,1,0, 1,2'd0,0,0,0, "R12");
        step(0,0,1,0, 1,2'd0,1,1,0, "R4");
        step(0,0,0,1, 0,2'd0,0,1,0, "R6");   // self refresh entry
        step(0,0,0,1, 0,2'd0,0,1,0, "R8");
        step(0,1,1,1, 1,2'd0,0,1,0, "R8");
        step(0,0,1,1, 0,2'd2,0,1,0, "R2");   // activate as clock enable falls
        step(0,0,1,1, 1,2'd1,0,1,0, "R12");  // previous clock enable low
        step(0,1,1,1, 1,2'd0,0,1,0, "R12");
        for (int i = 0; i < 4000; i++) begin
            int p;
            logic [2:0] s;
            p = int'($urandom_range(0, 99));
            s = 3'($urandom);
            step(p < 15, s[2], s[1], s[0], ($urandom_range(0, 9) != 0),
                 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule